// File: doc/BRIEF.md
# 8-to-16-bit NAND Bus Bridge

This block sits between a processor's register port and an 8-bit NAND flash device. The processor sees a small register window of five byte-wide locations. A phase/control register drives the device's latch-enable, chip-enable and power lines directly. A data location turns every 16-bit host access into two device byte cycles; the first byte travels in the low half of the word. A byte-wide access to that location makes only one device cycle, which is how command and address bytes are issued.

The device's ready/busy line is brought in through a two-flop synchronizer. Its level is reported as a busy status bit. Its rising edge latches a ready flag, which can drive an interrupt output once a mask bit allows it.

Host accesses use a request/acknowledge handshake: the host holds `req` until `ack` pulses, so each access stalls for as long as its device strobes take. A single state machine sequences the work. Its states are IDLE, STROBE, RECOVER and DONE, with these transitions:

- IDLE to STROBE when a data access is accepted.
- IDLE to DONE for a register access or a suppressed write.
- STROBE to RECOVER after the strobe width.
- RECOVER back to STROBE when the second byte is still to do.
- RECOVER to DONE after the last byte.
- DONE to IDLE unconditionally.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset the chip-enable pin is high (deselected), CLE, ALE, power bits and interrupt are low, both strobes are high and `ack` is low.
- R2: Every accepted request ends with `ack` high for exactly one clock. A register access acknowledges in the clock after the request is sampled.
- R3: Offset 4 holds the phase/control byte and reads back unchanged. Its bits drive the pins as follows: bit 0 drives CLE, bit 1 drives ALE, bit 4 set drives `nd_ce_n` low, and bits 3:2 drive `pwr_ctl`. So 0x95 gives command phase, 0x96 address phase, 0x94 data phase, 0x00 standby, 0x0C power on and 0x08 power off.
- R4: A 16-bit write to offset 0 makes two write cycles, bits 7:0 first and bits 15:8 second. Each holds `nd_we_n` low for STROBE_CLKS clocks, with the byte driven on `nd_io_out` and `nd_io_oe` high.
- R5: A 16-bit read from offset 0 makes two read cycles, each holding `nd_re_n` low for STROBE_CLKS clocks. The first byte returns in `hst_rdata[7:0]` and the second in `hst_rdata[15:8]`.
- R6: A byte-size (`hst_size16`=0) access to offset 0 makes one device cycle. A read of this kind returns the byte in bits 7:0, with bits 15:8 zero.
- R7: When bit 7 (write enable) of the control byte is clear, a write to offset 0 produces no `nd_we_n` strobe but is still acknowledged.
- R8: Offset 5 reads 0x80 while the synchronized ready/busy line is low and 0x00 while it is high.
- R9: A rising edge on `nd_rb` sets the ready flag, which reads as bit 0 of offset 6. A falling edge does not set it.
- R10: Writing a 1 to bit 0 of offset 6 clears the flag, so 0x0F clears it. A rising edge in the same clock wins over the clear.
- R11: `irq` is high exactly when the flag is set and bit 0 of the mask at offset 7 is set. 0x81 enables it, 0x00 disables it, and the mask reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host request, held until ack |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register offset |
| hst_size16 | input | 1 | 1 = 16-bit data access, 0 = byte |
| hst_wdata | input | 16 | Write data |
| hst_rdata | output | 16 | Read data, valid with ack |
| hst_ack | output | 1 | One-clock completion pulse |
| nd_io_in | input | 8 | Device data bus input |
| nd_io_out | output | 8 | Device data bus output |
| nd_io_oe | output | 1 | Device data bus output enable |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_rb | input | 1 | Device ready (1) / busy (0), asynchronous |
| pwr_ctl | output | 2 | Power/LED control bits |
| irq | output | 1 | Ready interrupt |

## Verification
Device writes are tried in several forms. A byte command under CLE and a 16-bit address word under ALE show the difference between one-cycle and two-cycle sequencing. The word 0x1234 makes byte order visible, since swapped halves give 0x12 first. Reads are tried as a 16-bit access and then a byte access, fed from a counting byte source, which shows both packing order and the zeroed upper half. A write with the write-enable bit clear must give no strobe. The ready line is toggled both ways, which separates edge detection from level reporting and shows the mask gating the interrupt.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } cyc_state_e;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_MODE = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;
    localparam logic [2:0] OFS_ISR  = 3'd6;
    localparam logic [2:0] OFS_IMR  = 3'd7;

    localparam int CTL_CLE = 0;
    localparam int CTL_ALE = 1;
    localparam int CTL_PWR = 2;
    localparam int CTL_CE  = 4;
    localparam int CTL_WE  = 7;
endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic busy,
    output logic ready_rise
);
    logic rb_meta, rb_sync, rb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_meta <= 1'b1;
            rb_sync <= 1'b1;
            rb_prev <= 1'b1;
        end else begin
            rb_meta <= rb_async;
            rb_sync <= rb_meta;
            rb_prev <= rb_sync;
        end
    end

    assign busy       = ~rb_sync;
    assign ready_rise = rb_sync & ~rb_prev;

    // R9: an edge is reported for a single clock only
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rise |=> !ready_rise);
endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
    import nbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic       busy,
    input  logic       ready_rise,
    output logic [7:0] ctl,
    output logic [7:0] rd_byte,
    output logic       irq
);
    logic [7:0] mask_q;
    logic       flag_q;
    logic       clr_hit;

    assign clr_hit = wr_en && (addr == OFS_ISR) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl    <= 8'h00;
            mask_q <= 8'h00;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_MODE) ctl    <= wdata;
            if (wr_en && addr == OFS_IMR)  mask_q <= wdata;
            flag_q <= ready_rise | (flag_q & ~clr_hit);
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MODE: rd_byte = ctl;
            OFS_STAT: rd_byte = {busy, 7'b0};
            OFS_ISR:  rd_byte = {7'b0, flag_q};
            OFS_IMR:  rd_byte = mask_q;
            default:  rd_byte = 8'h00;
        endcase
    end

    assign irq = flag_q & mask_q[0];

    assert_rise_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rise |=> irq == mask_q[0]);
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !ready_rise) |=> !irq);
endmodule

// File: rtl/nbb_cycle_fsm.sv
module nbb_cycle_fsm
    import nbb_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic        size16,
    input  logic [15:0] wdata,
    input  logic        wr_allowed,
    input  logic [7:0]  reg_rd_byte,
    input  logic [7:0]  io_in,
    output logic        accept,
    output logic        ack,
    output logic [15:0] rdata,
    output logic [7:0]  io_out,
    output logic        io_oe,
    output logic        we_n,
    output logic        re_n
);
    localparam int CNT_W = $clog2(STROBE_CLKS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    cyc_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             idx, two_bytes, is_wr;
    logic [15:0]      wbuf;
    logic             go_strobe;

    assign accept    = (state == ST_IDLE) && req;
    assign go_strobe = (addr == OFS_DATA) && !(we && !wr_allowed);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req) nxt = go_strobe ? ST_STROBE : ST_DONE;
            ST_STROBE:  if (cnt == CNT_LAST) nxt = ST_RECOVER;
            ST_RECOVER: nxt = (idx == two_bytes) ? ST_DONE : ST_STROBE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            idx       <= 1'b0;
            two_bytes <= 1'b0;
            is_wr     <= 1'b0;
            wbuf      <= 16'h0;
            rdata     <= 16'h0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    cnt       <= '0;
                    idx       <= 1'b0;
                    two_bytes <= size16;
                    is_wr     <= we;
                    wbuf      <= wdata;
                    rdata     <= go_strobe ? 16'h0 : {8'h00, reg_rd_byte};
                end
                ST_STROBE: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        if (!is_wr) begin
                            if (idx) rdata[15:8] <= io_in;
                            else     rdata[7:0]  <= io_in;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RECOVER: if (idx != two_bytes) idx <= 1'b1;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        ack    = (state == ST_DONE);
        we_n   = !((state == ST_STROBE) && is_wr);
        re_n   = !((state == ST_STROBE) && !is_wr);
        io_oe  = is_wr && ((state == ST_STROBE) || (state == ST_RECOVER));
        io_out = idx ? wbuf[15:8] : wbuf[7:0];
    end

    // strobe-width checker counter
    logic [CNT_W-1:0] chk_low;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              chk_low <= '0;
        else if (!we_n || !re_n) chk_low <= chk_low + 1'b1;
        else                     chk_low <= '0;
    end

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) || $rose(re_n)) |-> chk_low == CNT_W'(STROBE_CLKS));
    assert_bus_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> io_oe);
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_n || re_n);
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
    import nbb_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_req,
    input  logic        hst_we,
    input  logic [2:0]  hst_addr,
    input  logic        hst_size16,
    input  logic [15:0] hst_wdata,
    output logic [15:0] hst_rdata,
    output logic        hst_ack,
    input  logic [7:0]  nd_io_in,
    output logic [7:0]  nd_io_out,
    output logic        nd_io_oe,
    output logic        nd_cle,
    output logic        nd_ale,
    output logic        nd_ce_n,
    output logic        nd_we_n,
    output logic        nd_re_n,
    input  logic        nd_rb,
    output logic [1:0]  pwr_ctl,
    output logic        irq
);
    logic       busy, ready_rise, accept;
    logic [7:0] ctl, rd_byte;

    nbb_rb_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_async   (nd_rb),
        .busy       (busy),
        .ready_rise (ready_rise)
    );

    nbb_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept && hst_we),
        .addr       (hst_addr),
        .wdata      (hst_wdata[7:0]),
        .busy       (busy),
        .ready_rise (ready_rise),
        .ctl        (ctl),
        .rd_byte    (rd_byte),
        .irq        (irq)
    );

    nbb_cycle_fsm #(.STROBE_CLKS(STROBE_CLKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (hst_req),
        .we          (hst_we),
        .addr        (hst_addr),
        .size16      (hst_size16),
        .wdata       (hst_wdata),
        .wr_allowed  (ctl[CTL_WE]),
        .reg_rd_byte (rd_byte),
        .io_in       (nd_io_in),
        .accept      (accept),
        .ack         (hst_ack),
        .rdata       (hst_rdata),
        .io_out      (nd_io_out),
        .io_oe       (nd_io_oe),
        .we_n        (nd_we_n),
        .re_n        (nd_re_n)
    );

    assign nd_cle  = ctl[CTL_CLE];
    assign nd_ale  = ctl[CTL_ALE];
    assign nd_ce_n = ~ctl[CTL_CE];
    assign pwr_ctl = ctl[CTL_PWR +: 2];

    assert_no_we_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CTL_WE] && $fell(nd_we_n) |-> $past(ctl[CTL_WE]) == 1'b0 && 1'b0);
endmodule

// File: tb/nand_bus_bridge_bench.sv
module nand_bus_bridge_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        hst_req = 0, hst_we = 0, hst_size16 = 0;
    logic [2:0]  hst_addr = 0;
    logic [15:0] hst_wdata = 0;
    logic [15:0] hst_rdata;
    logic        hst_ack;
    logic [7:0]  nd_io_in = 8'h00;
    logic [7:0]  nd_io_out;
    logic        nd_io_oe, nd_cle, nd_ale, nd_ce_n, nd_we_n, nd_re_n;
    logic        nd_rb = 1;
    logic [1:0]  pwr_ctl;
    logic        irq;

    int checks = 0, fails = 0;

    nand_bus_bridge u_nand_bus_bridge (.*);

    always #10 clk = ~clk;

    // write-strobe monitor
    logic [7:0] wr_bytes [0:7];
    int         wr_width [0:7];
    int         wr_n = 0, low_cnt = 0;
    logic [7:0] last_byte;
    logic       prev_we = 1;
    always @(negedge clk) begin
        if (!nd_we_n) begin
            low_cnt++;
            last_byte = nd_io_out;
        end else if (!prev_we) begin
            if (wr_n < 8) begin
                wr_bytes[wr_n] = last_byte;
                wr_width[wr_n] = low_cnt;
            end
            wr_n++;
            low_cnt = 0;
        end
        prev_we = nd_we_n;
    end

    // read data source
    logic [7:0] rd_next = 8'hA0;
    always @(negedge nd_re_n) begin
        nd_io_in = rd_next;
        rd_next  = rd_next + 1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int lat;
    task automatic host(input logic we, input logic [2:0] a, input logic s16,
                        input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        hst_req = 1; hst_we = we; hst_addr = a; hst_size16 = s16; hst_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!hst_ack);
        rd = hst_rdata;
        hst_req = 0;
    endtask

    task automatic t_reset();
        check("R1 ce_n", nd_ce_n, 1);
        check("R1 cle/ale", {nd_cle, nd_ale}, 0);
        check("R1 strobes", {nd_we_n, nd_re_n}, 2'b11);
        check("R1 irq/ack/pwr", {irq, hst_ack, pwr_ctl}, 0);
    endtask

    task automatic t_mode();
        logic [15:0] r;
        host(1, 3'd4, 0, 16'h0095, r);
        check("R2 register ack latency", lat, 1);
        check("R3 command phase pins", {nd_cle, nd_ale, nd_ce_n}, 3'b100);
        host(0, 3'd4, 0, 0, r);
        check("R3 readback", r, 16'h0095);
        host(1, 3'd4, 0, 16'h000C, r);
        check("R3 power on", {pwr_ctl, nd_ce_n}, 3'b111);
        host(1, 3'd4, 0, 16'h0008, r);
        check("R3 power off", pwr_ctl, 2'b10);
        host(1, 3'd4, 0, 16'h0000, r);
        check("R3 standby", {nd_ce_n, nd_cle, nd_ale}, 3'b100);
    endtask

    task automatic t_writes();
        logic [15:0] r;
        host(1, 3'd4, 0, 16'h0095, r);
        wr_n = 0;
        host(1, 3'd0, 0, 16'hFF70, r);
        check("R6 byte command count", wr_n, 1);
        check("R6 byte command value", wr_bytes[0], 8'h70);
        check("R4 strobe width", wr_width[0], 3);
        host(1, 3'd4, 0, 16'h0096, r);
        check("R3 address phase pins", {nd_cle, nd_ale}, 2'b01);
        wr_n = 0;
        host(1, 3'd0, 1, 16'h1234, r);
        check("R4 word write count", wr_n, 2);
        check("R4 byte order", {wr_bytes[0], wr_bytes[1]}, 16'h3412);
        check("R4 second strobe width", wr_width[1], 3);
        host(1, 3'd4, 0, 16'h0014, r);
        wr_n = 0;
        host(1, 3'd0, 1, 16'hBEEF, r);
        repeat (2) @(negedge clk);
        check("R7 suppressed write strobes", wr_n, 0);
    endtask

    task automatic t_reads();
        logic [15:0] r;
        host(1, 3'd4, 0, 16'h0094, r);
        host(0, 3'd0, 1, 0, r);
        check("R5 word read packing", r, 16'hA1A0);
        host(0, 3'd0, 0, 0, r);
        check("R6 byte read", r, 16'h00A2);
    endtask

    task automatic t_ready();
        logic [15:0] r;
        nd_rb = 0;
        repeat (4) @(negedge clk);
        host(0, 3'd5, 0, 0, r);
        check("R8 busy status", r, 16'h0080);
        host(0, 3'd6, 0, 0, r);
        check("R9 falling edge ignored", r, 16'h0000);
        nd_rb = 1;
        repeat (4) @(negedge clk);
        host(0, 3'd5, 0, 0, r);
        check("R8 ready status", r, 16'h0000);
        host(0, 3'd6, 0, 0, r);
        check("R9 flag set on rise", r, 16'h0001);
        check("R11 masked irq", irq, 0);
        host(1, 3'd7, 0, 16'h0081, r);
        check("R11 enabled irq", irq, 1);
        host(0, 3'd7, 0, 0, r);
        check("R11 mask readback", r, 16'h0081);
        host(1, 3'd6, 0, 16'h000F, r);
        @(negedge clk);
        check("R10 clear drops irq", irq, 0);
        host(0, 3'd6, 0, 0, r);
        check("R10 flag cleared", r, 16'h0000);
        host(1, 3'd7, 0, 16'h0000, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_mode();
        t_writes();
        t_reads();
        t_ready();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule